// File: doc/BRIEF.md
# Strobe-Handshaked FIFO with Occupancy Flags

This block is a 64-word by 9-bit first-in first-out buffer that a producer and a consumer reach through pulse strobes instead of enables. A producer raises and then drops its load strobe. The high-to-low transition, seen on the system clock, stores the word present on the data input. A consumer does the same with its unload strobe to take the word at the head. Two registered handshakes report whether the buffer can take a word and whether a valid word sits on the output. A word written into an empty buffer moves to the output on its own, without an unload strobe. Taking a word from a full buffer frees a slot at once.

Two registered flags summarise occupancy. The first goes high at half depth. The second marks either end of the range: it is high near empty and near full, and low in the middle. An active-low master reset empties the buffer. An output enable forces the data output to zero and drops a valid qualifier; it does not touch the stored contents.

Occupancy counts every stored word, including the one presented on the output.

Top module: `fifo_handshake`

## Requirements
- R1: While and right after master reset (masterRstN low), inReady is 1, outReady is 0, halfFull is 0, nearEdge is 1, dataValid is 0 and dataOut is 0.
- R2: A word is accepted when shiftIn is sampled high on one clock edge and low on the next while inReady is 1. Accepted words leave dataOut in the order they were written.
- R3: A word written into an empty FIFO appears on dataOut, with outReady high, one clock edge after the edge that accepted it, with no shiftOut.
- R4: While outReady and outEn stay high, dataOut does not change.
- R5: A shiftOut falling transition sampled while outReady is 1 removes the head word. outReady is then low for exactly one cycle, and rises on the next edge with the following word if one is stored.
- R6: A read from a full FIFO raises inReady on the same edge that accepts the read.
- R7: A shiftIn fall while inReady is 0, or a shiftOut fall while outReady is 0, is ignored. It changes no pointer, flag or output.
- R8: halfFull is 1 exactly when 32 or more words are stored. It changes on the edge that moves occupancy between 31 and 32.
- R9: nearEdge is 1 when 8 or fewer words, or 56 or more words, are stored, and 0 otherwise.
- R10: With outEn at 0, dataOut is 0 and dataValid is 0. Stored data and flags are unaffected. dataValid equals outReady while outEn is 1.
- R11: At 64 stored words inReady is 0. Flags and handshakes are registered and change only on clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| masterRstN | input | 1 | Active-low asynchronous master reset |
| shiftIn | input | 1 | Load strobe; its falling transition writes dataIn |
| shiftOut | input | 1 | Unload strobe; its falling transition removes the head word |
| dataIn | input | 9 | Word to be written |
| outEn | input | 1 | Output enable for dataOut and dataValid |
| dataOut | output | 9 | Head word, or zero while outEn is low |
| dataValid | output | 1 | outReady qualified by outEn |
| inReady | output | 1 | High when a slot is free |
| outReady | output | 1 | High when dataOut holds a valid head word |
| halfFull | output | 1 | High at 32 or more stored words |
| nearEdge | output | 1 | High at 8 or fewer, or 56 or more, stored words |

## Verification
The bench goes after the fall-through into an empty buffer. A design that needs an extra unload strobe there would keep outReady low with a word stored. It checks the one-cycle outReady gap after each read, which a design with a stale head would skip by keeping the old word marked valid. It exercises the bubble-back from full and strobes ignored at full and at empty; a design that moved a pointer there would duplicate or lose words in the drained sequence. It also checks the exact occupancies 8/9, 31/32 and 55/56 where the two flags switch, and the output enable, which must hide the word without disturbing the stored contents.

// File: rtl/fifo_hs_pkg.sv
package fifo_hs_pkg;
  // strobes sent from control to datapath in one cycle
  typedef struct packed {
    logic wrEn;     // store dataIn at the write address
    logic loadHead; // copy the word at the read address into the head register
  } dpStrobes_t;
endpackage

// File: rtl/fifo_hs_falldet.sv
module fifo_hs_falldet (
  input  logic clk,
  input  logic masterRstN,
  input  logic strobeIn,
  output logic fallSeen
);
  logic prevLevel;

  always_ff @(posedge clk or negedge masterRstN) begin
    if (!masterRstN) prevLevel <= 1'b0;
    else             prevLevel <= strobeIn;
  end

  assign fallSeen = prevLevel & ~strobeIn;
endmodule

// File: rtl/fifo_hs_ctrl.sv
module fifo_hs_ctrl #(
  parameter int ADDR_W     = 6,
  parameter int ALMOST_GAP = 8
) (
  input  logic                     clk,
  input  logic                     masterRstN,
  input  logic                     shiftIn,
  input  logic                     shiftOut,
  output fifo_hs_pkg::dpStrobes_t  strobes,
  output logic [ADDR_W-1:0]        wrAddr,
  output logic [ADDR_W-1:0]        rdAddr,
  output logic                     inReady,
  output logic                     outReady,
  output logic                     halfFull,
  output logic                     nearEdge
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int PTR_W     = ADDR_W + 1;
  localparam int HALF_MARK = DEPTH / 2;
  localparam int LOW_MARK  = ALMOST_GAP;
  localparam int HIGH_MARK = DEPTH - ALMOST_GAP;

  logic inFall, outFall;
  logic wrFire, rdFire, loadHead;
  logic [PTR_W-1:0] wrPtr, rdPtr, wrPtrNext, rdPtrNext;
  logic [PTR_W-1:0] occNow, occNext;

  fifo_hs_falldet u_inDet (
    .clk(clk), .masterRstN(masterRstN), .strobeIn(shiftIn), .fallSeen(inFall)
  );
  fifo_hs_falldet u_outDet (
    .clk(clk), .masterRstN(masterRstN), .strobeIn(shiftOut), .fallSeen(outFall)
  );

  assign occNow    = wrPtr - rdPtr;
  assign wrFire    = inFall & inReady;
  assign rdFire    = outFall & outReady;
  assign loadHead  = ~outReady & (occNow != '0);
  assign wrPtrNext = wrPtr + PTR_W'(wrFire);
  assign rdPtrNext = rdPtr + PTR_W'(rdFire);
  assign occNext   = wrPtrNext - rdPtrNext;

  assign strobes.wrEn     = wrFire;
  assign strobes.loadHead = loadHead;
  assign wrAddr = wrPtr[ADDR_W-1:0];
  assign rdAddr = rdPtr[ADDR_W-1:0];

  always_ff @(posedge clk or negedge masterRstN) begin
    if (!masterRstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      inReady  <= 1'b1;
      outReady <= 1'b0;
      halfFull <= 1'b0;
      nearEdge <= 1'b1;
    end else begin
      wrPtr    <= wrPtrNext;
      rdPtr    <= rdPtrNext;
      inReady  <= ~occNext[ADDR_W];
      if (rdFire)        outReady <= 1'b0;
      else if (loadHead) outReady <= 1'b1;
      halfFull <= (occNext >= PTR_W'(HALF_MARK));
      nearEdge <= (occNext <= PTR_W'(LOW_MARK)) || (occNext >= PTR_W'(HIGH_MARK));
    end
  end
endmodule

// File: rtl/fifo_hs_datapath.sv
module fifo_hs_datapath #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    masterRstN,
  input  fifo_hs_pkg::dpStrobes_t strobes,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic                    outReady,
  input  logic                    outEn,
  output logic [DATA_W-1:0]       dataOut,
  output logic                    dataValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] storage [DEPTH];
  logic [DATA_W-1:0] headWord;

  always_ff @(posedge clk) begin
    if (strobes.wrEn) storage[wrAddr] <= dataIn;
  end

  always_ff @(posedge clk or negedge masterRstN) begin
    if (!masterRstN)          headWord <= '0;
    else if (strobes.loadHead) headWord <= storage[rdAddr];
  end

  assign dataOut   = outEn ? headWord : '0;
  assign dataValid = outEn & outReady;
endmodule

// File: rtl/fifo_handshake.sv
module fifo_handshake #(
  parameter int DATA_W     = 9,
  parameter int ADDR_W     = 6,
  parameter int ALMOST_GAP = 8
) (
  input  logic              clk,
  input  logic              masterRstN,
  input  logic              shiftIn,
  input  logic              shiftOut,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              inReady,
  output logic              outReady,
  output logic              halfFull,
  output logic              nearEdge
);
  fifo_hs_pkg::dpStrobes_t strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  fifo_hs_ctrl #(.ADDR_W(ADDR_W), .ALMOST_GAP(ALMOST_GAP)) u_ctrl (
    .clk(clk), .masterRstN(masterRstN), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inReady(inReady), .outReady(outReady), .halfFull(halfFull), .nearEdge(nearEdge)
  );

  fifo_hs_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .masterRstN(masterRstN), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .dataIn(dataIn),
    .outReady(outReady), .outEn(outEn), .dataOut(dataOut), .dataValid(dataValid)
  );
endmodule

// File: rtl/fifo_handshake_chk.sv
module fifo_handshake_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              masterRstN,
  input logic              shiftIn,
  input logic              shiftOut,
  input logic              outEn,
  input logic [DATA_W-1:0] dataOut,
  input logic              inReady,
  input logic              outReady,
  input logic              halfFull,
  input logic              nearEdge
);
  logic chkPrevIn, chkPrevOut;

  always_ff @(posedge clk or negedge masterRstN) begin
    if (!masterRstN) begin
      chkPrevIn  <= 1'b0;
      chkPrevOut <= 1'b0;
    end else begin
      chkPrevIn  <= shiftIn;
      chkPrevOut <= shiftOut;
    end
  end

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!masterRstN)
    (outReady && outEn && $past(outReady) && $past(outEn)) |-> $stable(dataOut)); // R4

  AST_READ_DROPS_READY: assert property (@(posedge clk) disable iff (!masterRstN)
    (outReady && chkPrevOut && !shiftOut) |=> !outReady); // R5

  AST_OUT_READY_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!masterRstN)
    $fell(outReady) |-> $past(chkPrevOut && !shiftOut)); // R7

  AST_IN_READY_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!masterRstN)
    $fell(inReady) |-> $past(chkPrevIn && !shiftIn)); // R7

  AST_FULL_FLAGS: assert property (@(posedge clk) disable iff (!masterRstN)
    !inReady |-> (halfFull && nearEdge)); // R11

  AST_HALF_NOT_EMPTY: assert property (@(posedge clk) disable iff (!masterRstN)
    halfFull |-> outReady || $past(outReady)); // R8
endmodule

bind fifo_handshake fifo_handshake_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .masterRstN(masterRstN), .shiftIn(shiftIn), .shiftOut(shiftOut),
  .outEn(outEn), .dataOut(dataOut), .inReady(inReady), .outReady(outReady),
  .halfFull(halfFull), .nearEdge(nearEdge)
);

// File: tb/fifo_handshake_bench.sv
module fifo_handshake_bench;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic masterRstN = 1'b0;
  logic shiftIn = 1'b0, shiftOut = 1'b0, outEn = 1'b1;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic dataValid, inReady, outReady, halfFull, nearEdge;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  // model state after the latest rising edge
  logic [DW-1:0] mQ[$];
  logic [DW-1:0] mHead = '0;
  bit mPrevIn = 0, mPrevOut = 0, mOutReady = 0, mInReady = 1, mHalf = 0, mEdge = 1;

  always #2.5 clk = ~clk;

  fifo_handshake u_fifo_handshake (
    .clk(clk), .masterRstN(masterRstN), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .dataIn(dataIn), .outEn(outEn), .dataOut(dataOut), .dataValid(dataValid),
    .inReady(inReady), .outReady(outReady), .halfFull(halfFull), .nearEdge(nearEdge)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit flagHalf(int occ); return occ >= 32; endfunction
  function automatic bit flagEdge(int occ); return (occ <= 8) || (occ >= 56); endfunction

  task automatic compareAll();
    logic [DW-1:0] expData;
    expData = outEn ? mHead : '0;
    chk(inReady == mInReady, "R11 inReady", inReady, mInReady);
    chk(outReady == mOutReady, "R5 outReady", outReady, mOutReady);
    chk(dataOut == expData, "R2 dataOut", dataOut, expData);
    chk(dataValid == (outEn & mOutReady), "R10 dataValid", dataValid, outEn & mOutReady);
    chk(halfFull == mHalf, "R8 halfFull", halfFull, mHalf);
    chk(nearEdge == mEdge, "R9 nearEdge", nearEdge, mEdge);
  endtask

  task automatic modelAdvance(bit si, bit so, logic [DW-1:0] din);
    bit wr, rd, ld;
    int occ;
    wr = mPrevIn & ~si & mInReady;
    rd = mPrevOut & ~so & mOutReady;
    ld = !mOutReady && (mQ.size() > 0);
    if (ld) mHead = mQ[0];
    if (rd) void'(mQ.pop_front());
    if (wr) mQ.push_back(din);
    if (rd) mOutReady = 0;
    else if (ld) mOutReady = 1;
    occ = mQ.size();
    mInReady = occ < 64;
    mHalf = flagHalf(occ);
    mEdge = flagEdge(occ);
    mPrevIn = si;
    mPrevOut = so;
  endtask

  task automatic step(bit si, bit so, logic [DW-1:0] din, bit oe);
    @(negedge clk);
    compareAll();
    shiftIn = si; shiftOut = so; dataIn = din; outEn = oe;
    modelAdvance(si, so, din);
  endtask

  task automatic writePulse(logic [DW-1:0] d);
    step(1, 0, d, 1);
    step(0, 0, d, 1);
  endtask

  task automatic readPulse();
    step(0, 1, '0, 1);
    step(0, 0, '0, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: values while reset is held
    repeat (3) @(negedge clk);
    chk(inReady == 1 && outReady == 0, "R1 handshakes in reset", {inReady, outReady}, 2);
    chk(halfFull == 0 && nearEdge == 1, "R1 flags in reset", {halfFull, nearEdge}, 1);
    chk(dataValid == 0 && dataOut == 0, "R1 outputs in reset", dataOut, 0);
    masterRstN = 1'b1;

    // R7: unload strobe on an empty buffer is ignored
    readPulse();
    step(0, 0, '0, 1);
    chk(outReady == 0 && inReady == 1, "R7 read on empty", outReady, 0);

    // R3: fall-through into empty
    writePulse(9'h1A5);
    step(0, 0, '0, 1);
    step(0, 0, '0, 1);
    chk(outReady == 1 && dataOut == 9'h1A5, "R3 fall-through", dataOut, 9'h1A5);

    // R10: output enable hides the word but keeps it
    step(0, 0, '0, 0);
    step(0, 0, '0, 0);
    chk(dataOut == 0 && dataValid == 0, "R10 outEn low", dataOut, 0);
    step(0, 0, '0, 1);
    step(0, 0, '0, 1);
    chk(dataOut == 9'h1A5 && dataValid == 1, "R10 word kept", dataOut, 9'h1A5);

    // fill to 64 (flags cross 8/9, 31/32, 55/56 along the way)
    for (int i = 1; i < 64; i++) writePulse(DW'($urandom_range(0, 511)));
    step(0, 0, '0, 1);
    chk(inReady == 0, "R11 full", inReady, 0);
    // R7: writes while full are ignored
    writePulse(9'h0FF);
    writePulse(9'h0EE);
    step(0, 0, '0, 1);
    chk(inReady == 0 && mQ.size() == 64, "R7 write on full", inReady, 0);

    // R6: bubble-back
    step(0, 1, '0, 1);
    step(0, 0, '0, 1);
    step(0, 0, '0, 1);
    chk(inReady == 1, "R6 bubble-back", inReady, 1);
    writePulse(9'h133);

    // drain everything, order checked via dataOut model
    for (int i = 0; i < 70; i++) begin
      readPulse();
      step(0, 0, '0, 1);
    end
    chk(outReady == 0 && mQ.size() == 0, "R2 drained", outReady, 0);

    // constrained random with changing write/read bias
    for (int phase = 0; phase < 8; phase++) begin
      int pw, pr;
      pw = (phase % 2 == 0) ? 75 : 30;
      pr = (phase % 2 == 0) ? 25 : 70;
      for (int c = 0; c < 1200; c++) begin
        bit si, so, oe;
        si = $urandom_range(0, 99) < pw;
        so = $urandom_range(0, 99) < pr;
        oe = $urandom_range(0, 99) < 90;
        step(si, so, DW'($urandom_range(0, 511)), oe);
      end
    end
    step(0, 0, '0, 1);

    // R1: reset mid-stream empties the buffer
    @(negedge clk);
    masterRstN = 1'b0;
    shiftIn = 0; shiftOut = 0;
    @(negedge clk);
    chk(inReady == 1 && outReady == 0 && nearEdge == 1 && halfFull == 0,
        "R1 reset mid-run", {inReady, outReady, nearEdge, halfFull}, 4'b1010);
    masterRstN = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule